// File: doc/BRIEF.md
# Per-Core Local Interrupt Aggregator

This block gathers the interrupt lines that belong to each core of a small multi-core cluster and turns them into one pending word and one interrupt line per core. Every core brings four generic-timer lines, a mailbox summary line and a performance-monitor line. One fast line from the graphics side is shared by the cluster and is delivered to a single core chosen by a parameter.

Software controls the block over a simple 32-bit register bus. Each core has its own timer-enable register. Performance-monitor routing is changed through a write-one-to-set register and a write-one-to-clear register, and both take a one-hot core mask. Each core also has a read-only pending register. Sources are level-sensitive and are never latched: a pending bit is the live source level gated by its enable. Software services the lowest-numbered set bit first, so the bit positions set the priority order.

Top module: `lirq_aggregator`

## Requirements
- R1: After reset all timer enables and all routing bits are zero, `core_irq_o` is low for every core, and every register reads zero.
- R2: The timer-enable register of core c is at byte offset 0x40 + 4*c. Bits 3:0 hold the enables, and a write replaces them. Bits 31:4 are not stored and read as zero.
- R3: Pending bits 3:0 of core c are the timer lines of core c (bit 0 secure physical, 1 non-secure physical, 2 hypervisor physical, 3 virtual), each ANDed with the enable bit of the same index.
- R4: Writing to offset 0x10 sets routing for every core whose bit in the written value is 1 and leaves the other cores' routing unchanged. A read of 0x10 returns the routing mask in bits NUM_CORES-1:0.
- R5: Writing to offset 0x14 clears routing for every core whose bit in the written value is 1 and leaves the other cores' routing unchanged. A read of 0x14 also returns the routing mask.
- R6: Pending bit 9 of core c is that core's performance-monitor line ANDed with its routing bit.
- R7: Pending bit 4 of core c is that core's mailbox line, with no mask. Pending bit 8 carries the shared graphics line on core GPU_CORE only (default 0) and is zero on every other core.
- R8: The pending register of core c is at offset 0x60 + 4*c and is read-only. Writes to it change no register. Its bits other than 3:0, 4, 8 and 9 read zero.
- R9: `core_irq_o[c]` is high exactly when core c's pending word is non-zero. It falls as soon as the source drops or is masked.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change no register.
- R11: `bus_rdata` is registered. It is updated on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tmr_irq_i | input | NUM_CORES*4 | Timer lines, four per core, core c at bits 4c+3:4c |
| mbox_irq_i | input | NUM_CORES | Mailbox summary line per core |
| gpu_irq_i | input | 1 | Shared fast graphics line |
| pmu_irq_i | input | NUM_CORES | Performance-monitor line per core |
| core_irq_o | output | NUM_CORES | Interrupt line per core |

## Verification
A register write takes effect on the clock edge that samples it. From that edge on it shows in the pending word and in `core_irq_o`, which are combinational from the sources and the register state. Read data appears on the edge that samples `bus_rd`, so one cycle after the strobe. The bench drives every input at a falling edge and samples at the next falling edge, one full edge after the result is due. It changes no source during a read, and it checks that `bus_rdata` holds through a later write. The expected pending words come from a bench model of the enables and routing, which is updated by directed and seeded random register traffic.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   localparam int DATA_W        = 32;
   localparam int TMR_PER_CORE  = 4;
   localparam int MAX_CORES     = 8;
   localparam int REG_STRIDE    = 4;
   // pending word bit positions; software takes the lowest set bit first
   localparam int BIT_TMR0      = 0;
   localparam int BIT_MBOX      = 4;
   localparam int BIT_GPU       = 8;
   localparam int BIT_PMU       = 9;
   // register offsets
   localparam int OFS_ROUTE_SET = 'h10;
   localparam int OFS_ROUTE_CLR = 'h14;
   localparam int OFS_TMR_EN    = 'h40;
   localparam int OFS_PEND      = 'h60;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DATA_W-1:0]                 wdata,
   output logic [NUM_CORES*TMR_PER_CORE-1:0] tmr_en,
   output logic [NUM_CORES-1:0]              route
);
   localparam int SEL_W = (NUM_CORES > TMR_PER_CORE) ? NUM_CORES : TMR_PER_CORE;

   logic set_hit, clr_hit;
   logic unused_wdata;

   assign set_hit      = wr_en && (addr == ADDR_W'(OFS_ROUTE_SET));
   assign clr_hit      = wr_en && (addr == ADDR_W'(OFS_ROUTE_CLR));
   assign unused_wdata = ^wdata[DATA_W-1:SEL_W];

   always_ff @(posedge clk) begin
      if (!rst_n)       route <= '0;
      else if (set_hit) route <= route | wdata[NUM_CORES-1:0];
      else if (clr_hit) route <= route & ~wdata[NUM_CORES-1:0];
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic                    hit;
      logic [TMR_PER_CORE-1:0] en_q;
      assign hit = wr_en && (addr == ADDR_W'(OFS_TMR_EN + REG_STRIDE * c));
      always_ff @(posedge clk) begin
         if (!rst_n)   en_q <= '0;
         else if (hit) en_q <= wdata[TMR_PER_CORE-1:0];
      end
      assign tmr_en[c*TMR_PER_CORE +: TMR_PER_CORE] = en_q;
   end
endmodule

// File: rtl/lirq_core_merge.sv
module lirq_core_merge
   import lirq_pkg::*;
#(
   parameter bit HAS_GPU = 1'b0
) (
   input  logic [TMR_PER_CORE-1:0] tmr_raw,
   input  logic [TMR_PER_CORE-1:0] tmr_en,
   input  logic                    mbox_raw,
   input  logic                    gpu_raw,
   input  logic                    pmu_raw,
   input  logic                    pmu_route,
   output logic [DATA_W-1:0]       pend
);
   logic gpu_bit;
   assign gpu_bit = gpu_raw & HAS_GPU;

   always_comb begin
      pend                               = '0;
      pend[BIT_TMR0 +: TMR_PER_CORE]     = tmr_raw & tmr_en;
      pend[BIT_MBOX]                     = mbox_raw;
      pend[BIT_GPU]                      = gpu_bit;
      pend[BIT_PMU]                      = pmu_raw & pmu_route;
   end
endmodule

// File: rtl/lirq_aggregator.sv
module lirq_aggregator
   import lirq_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8,
   parameter int GPU_CORE  = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_wr,
   input  logic                              bus_rd,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [DATA_W-1:0]                 bus_wdata,
   output logic [DATA_W-1:0]                 bus_rdata,
   input  logic [NUM_CORES*TMR_PER_CORE-1:0] tmr_irq_i,
   input  logic [NUM_CORES-1:0]              mbox_irq_i,
   input  logic                              gpu_irq_i,
   input  logic [NUM_CORES-1:0]              pmu_irq_i,
   output logic [NUM_CORES-1:0]              core_irq_o
);
   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
      $error("lirq_aggregator: NUM_CORES must be 1..%0d", MAX_CORES);
   end
   if (GPU_CORE < 0 || GPU_CORE >= NUM_CORES) begin : g_bad_gpu
      $error("lirq_aggregator: GPU_CORE out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lirq_aggregator: ADDR_W must be at least 8");
   end

   logic [NUM_CORES*TMR_PER_CORE-1:0] tmr_en;
   logic [NUM_CORES-1:0]              route;
   logic [NUM_CORES*DATA_W-1:0]       pend_flat;
   logic [DATA_W-1:0]                 rd_word;

   lirq_regs #(
      .NUM_CORES (NUM_CORES),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .tmr_en (tmr_en),
      .route  (route)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      lirq_core_merge #(
         .HAS_GPU (c == GPU_CORE)
      ) u_merge (
         .tmr_raw   (tmr_irq_i[c*TMR_PER_CORE +: TMR_PER_CORE]),
         .tmr_en    (tmr_en[c*TMR_PER_CORE +: TMR_PER_CORE]),
         .mbox_raw  (mbox_irq_i[c]),
         .gpu_raw   (gpu_irq_i),
         .pmu_raw   (pmu_irq_i[c]),
         .pmu_route (route[c]),
         .pend      (pend_flat[c*DATA_W +: DATA_W])
      );
      assign core_irq_o[c] = |pend_flat[c*DATA_W +: DATA_W];
   end

   always_comb begin
      rd_word = '0;
      if (bus_addr == ADDR_W'(OFS_ROUTE_SET) || bus_addr == ADDR_W'(OFS_ROUTE_CLR))
         rd_word[NUM_CORES-1:0] = route;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (bus_addr == ADDR_W'(OFS_TMR_EN + REG_STRIDE * c))
            rd_word[TMR_PER_CORE-1:0] = tmr_en[c*TMR_PER_CORE +: TMR_PER_CORE];
         if (bus_addr == ADDR_W'(OFS_PEND + REG_STRIDE * c))
            rd_word = pend_flat[c*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end
endmodule

// File: rtl/lirq_aggregator_chk.sv
module lirq_aggregator_chk
   import lirq_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              bus_wr,
   input logic [ADDR_W-1:0]                 bus_addr,
   input logic [DATA_W-1:0]                 bus_wdata,
   input logic [NUM_CORES-1:0]              core_irq_o,
   input logic [NUM_CORES*TMR_PER_CORE-1:0] tmr_en,
   input logic [NUM_CORES-1:0]              route,
   input logic [NUM_CORES*DATA_W-1:0]       pend_flat
);
   localparam logic [DATA_W-1:0] LIVE_MASK =
      DATA_W'((1 << BIT_PMU) | (1 << BIT_GPU) | (1 << BIT_MBOX) | (((1 << TMR_PER_CORE) - 1) << BIT_TMR0));

   logic [NUM_CORES-1:0] wmask;
   logic                 pend_wr;
   logic                 unused_chk;

   assign wmask      = bus_wdata[NUM_CORES-1:0];
   assign unused_chk = ^bus_wdata;

   always_comb begin
      pend_wr = 1'b0;
      for (int c = 0; c < NUM_CORES; c++)
         if (bus_wr && bus_addr == ADDR_W'(OFS_PEND + REG_STRIDE * c)) pend_wr = 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (route == '0 && tmr_en == '0 && core_irq_o == '0));

   assert_route_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_ROUTE_SET)) |=> ((route & $past(wmask)) == $past(wmask)));

   assert_route_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_ROUTE_CLR)) |=> ((route & $past(wmask)) == '0));

   assert_pend_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend_wr |=> ($stable(route) && $stable(tmr_en)));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assert_timer_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_flat[c*DATA_W + BIT_TMR0 +: TMR_PER_CORE] & ~tmr_en[c*TMR_PER_CORE +: TMR_PER_CORE]) == '0);

      assert_pmu_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !route[c] |-> !pend_flat[c*DATA_W + BIT_PMU]);

      assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_flat[c*DATA_W +: DATA_W] & ~LIVE_MASK) == '0);

      assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
         core_irq_o[c] == (pend_flat[c*DATA_W +: DATA_W] != '0));
   end
endmodule

bind lirq_aggregator lirq_aggregator_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .core_irq_o (core_irq_o),
   .tmr_en     (tmr_en),
   .route      (route),
   .pend_flat  (pend_flat)
);

// File: tb/test_lirq_aggregator.sv
module test_lirq_aggregator;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] tmr = '0;
   logic [3:0]  mbox = '0, pmu = '0;
   logic        gpu = 1'b0;
   logic [3:0]  core_irq_o;

   logic [3:0]  ten_m [NC];
   logic [3:0]  route_m;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   lirq_aggregator #(.NUM_CORES(NC), .ADDR_W(8), .GPU_CORE(0)) i_lirq_aggregator (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_irq_i(tmr), .mbox_irq_i(mbox),
      .gpu_irq_i(gpu), .pmu_irq_i(pmu), .core_irq_o(core_irq_o)
   );

   function automatic logic [31:0] exp_pend(int c);
      logic [31:0] p = '0;
      p[3:0] = tmr[c*4 +: 4] & ten_m[c];
      p[4]   = mbox[c];
      p[8]   = gpu && (c == 0);
      p[9]   = pmu[c] & route_m[c];
      return p;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic check_cores(input string tag);
      logic [31:0] d;
      for (int c = 0; c < NC; c++) begin
         bus_read(8'h60 + 8'(4*c), d);
         check(tag, d, exp_pend(c));
         check("R9 irq level", 32'(core_irq_o[c]), 32'(|exp_pend(c)));
      end
   endtask

   task automatic check_ctrl(input string tag);
      logic [31:0] d;
      for (int c = 0; c < NC; c++) begin
         bus_read(8'h40 + 8'(4*c), d);
         check(tag, d, {28'd0, ten_m[c]});
      end
      bus_read(8'h10, d);
      check(tag, d, {28'd0, route_m});
   endtask

   initial begin
      logic [31:0] d;
      for (int c = 0; c < NC; c++) ten_m[c] = '0;
      route_m = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 irq after reset", 32'(core_irq_o), 32'd0);
      check_ctrl("R1 regs after reset");
      tmr = 16'hFFFF; pmu = 4'hF;
      check_cores("R1 sources masked after reset");

      // R2: timer enable, upper bits not stored
      bus_write(8'h44, 32'hFFFF_FFF5);
      ten_m[1] = 4'h5;
      check_ctrl("R2 timer enable readback");
      check_cores("R3 timer gating");

      // R4 / R5: set and clear routing
      bus_write(8'h10, 32'h5);  route_m = 4'h5;
      bus_write(8'h10, 32'h2);  route_m = 4'h7;
      bus_read(8'h10, d); check("R4 route set", d, 32'h7);
      bus_write(8'h14, 32'h1);  route_m = 4'h6;
      bus_read(8'h14, d); check("R5 route clear", d, 32'h6);
      check_cores("R6 pmu routing");

      // R7: mailbox unmasked, shared line on core 0 only
      tmr = '0; pmu = '0; mbox = 4'hA; gpu = 1'b1;
      check_cores("R7 mailbox and shared line");

      // R8: pending registers are read-only
      bus_write(8'h60, 32'hFFFF_FFFF);
      bus_write(8'h64, 32'h0);
      check_ctrl("R8 pending write ignored");
      check_cores("R8 pending after write");

      // R10: unmapped and misaligned offsets
      bus_write(8'h20, 32'hFFFF_FFFF);
      bus_write(8'h41, 32'hFFFF_FFFF);
      bus_write(8'h12, 32'hFFFF_FFFF);
      check_ctrl("R10 unmapped write ignored");
      bus_read(8'h20, d); check("R10 unmapped read", d, 32'd0);
      bus_read(8'h42, d); check("R10 misaligned read", d, 32'd0);

      // R9: level, not latched
      mbox = '0; gpu = 1'b0; tmr = 16'h0010;
      @(negedge clk);
      check("R9 irq rises with source", 32'(core_irq_o), 32'h2);
      tmr = '0;
      @(negedge clk);
      check("R9 irq falls with source", 32'(core_irq_o), 32'h0);

      // R11: read data holds while no read strobe
      bus_read(8'h44, d);
      bus_write(8'h44, 32'h0); ten_m[1] = 4'h0;
      check("R11 rdata holds", bus_rdata, 32'h5);

      // random traffic
      for (int i = 0; i < 300; i++) begin
         int op = int'($urandom % 4);
         int c  = int'($urandom % NC);
         logic [31:0] w = $urandom;
         case (op)
            0: begin bus_write(8'h40 + 8'(4*c), w); ten_m[c] = w[3:0]; end
            1: begin bus_write(8'h10, w); route_m = route_m | w[3:0]; end
            2: begin bus_write(8'h14, w); route_m = route_m & ~w[3:0]; end
            default: bus_write(8'h30, w);
         endcase
         tmr  = 16'($urandom);
         mbox = 4'($urandom);
         pmu  = 4'($urandom);
         gpu  = 1'($urandom);
         if (i % 10 == 0) check_ctrl("R2 R4 R5 random control");
         check_cores("R3 R6 R7 random pending");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule